// File: doc/BRIEF.md
# Fractional-N loop divider controller

This block holds the digital side of a fractional-N frequency synthesizer. A host loads an integer division count, a 16-bit fractional word and a reference division ratio through a three-wire serial port (clock, data, active-low select). The block counts pulses from an external dual-modulus prescaler and emits one feedback pulse toward the phase detector per loop-divider cycle. It also decides, through a single modulus-select output, whether the prescaler divides by P or by P+1.

A first-order 16-bit phase accumulator advances once per loop-divider cycle. Its carry selects the higher modulus for the first prescaler cycle of the next loop cycle, so the average division ratio carries a fractional part. A signed 12-bit modulation code is added to the fractional word before accumulation. Low-frequency audio presented as this code therefore shifts the average ratio, and with it the carrier.

A separate programmable counter divides the crystal clock (the block clock, nominally 16.8 MHz) down to the comparison frequency. The block has no streaming data path, so every pin is a plain level or strobe. The prescaler strobe and the serial lines are sampled in the block clock domain. The prescaler, phase detector, charge pump and VCO are outside the block.

Top module: `frac_divider_top`

## Requirements
- R1: While `rst_n` is low and after its release, `fb_pls`, `mod_hi` and `ref_pls` are 0. The active integer count is 4, the active fractional word is 0, the active reference ratio is 4, the accumulator is 0 and the modulation code is whatever `mod_code` presents.
- R2: A serial frame is 18 bits sent MSB first, each bit sampled on a rising edge of `ser_clk` while `ser_csn` is low. The first 2 bits are a register select and the last 16 are data. Select 0 writes the integer count (data bits 7:0), 1 writes the fractional word (bits 15:0), 2 writes the reference ratio (bits 9:0), and 3 writes nothing. A frame is accepted only on the rising edge of `ser_csn` and only if exactly 18 bits were shifted; any other bit count changes nothing.
- R3: Written integer and fractional words are held in shadow registers. They become active at the next feedback boundary: the loop cycle that starts there counts the new integer, and the accumulation at the end of that cycle uses the new fractional word.
- R4: With active integer count N (0 treated as 1), `fb_pls` is high for exactly one clock, in the cycle after the clock edge that samples the Nth `pre_pls` strobe of the loop cycle. It is never high otherwise.
- R5: At each feedback boundary the accumulator adds the effective fractional value modulo 2^16. `mod_hi` takes the carry out of that addition together with `fb_pls` and holds it until the next `pre_pls` strobe, which clears it unless that strobe is itself a boundary.
- R6: The effective fractional value is the active fractional word plus the sign-extended 12-bit two's complement `mod_code`, saturated to 0 below and 65535 above. `mod_code` is sampled at the boundary itself and is not buffered.
- R7: `ref_pls` is high for one clock out of every R clocks, where R is the active reference ratio and any value below 2 is treated as 2. A newly written ratio becomes active when the current reference period ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal reference clock; all logic runs on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_clk | input | 1 | Serial port bit clock |
| ser_dat | input | 1 | Serial port data, MSB first |
| ser_csn | input | 1 | Serial port select, active low; its rising edge ends a frame |
| mod_code | input | 12 | Signed modulation code added to the fractional word |
| pre_pls | input | 1 | One-clock strobe per prescaler output pulse |
| mod_hi | output | 1 | Prescaler modulus select: 1 selects P+1 |
| fb_pls | output | 1 | One-clock feedback pulse toward the phase detector |
| ref_pls | output | 1 | One-clock divided reference pulse |

## Verification
The fractional path is swept over words 0, 1, 0x5555, 0x8000 and 0xFFFF, each crossed with modulation codes 0, +2047, -2048 and -1. Each prescaler strobe is compared with a carry sequence worked out arithmetically. The zero word shows that no spurious carries appear. Words 1 and 0xFFFF, with the extreme codes, drive the saturation clamps at both ends, and 0x5555 and 0x8000 separate correct carry timing from an off-by-one in the accumulator.

Frames of 17 bits and frames with select 3 show that rejected writes leave the carry pattern untouched. A write made in the middle of a loop cycle shows that the old count finishes first. The reference divider is timed at ratios 0, 1, 3, 4 and 1000, which separates the clamp from normal counting.

// File: rtl/frac_div_pkg.sv
package frac_div_pkg;
  localparam int INT_W  = 8;
  localparam int FRAC_W = 16;
  localparam int MOD_W  = 12;
  localparam int REF_W  = 10;
  localparam int SEL_W  = 2;

  typedef enum logic [SEL_W-1:0] {
    SEL_INT  = 2'd0,
    SEL_FRAC = 2'd1,
    SEL_REF  = 2'd2,
    SEL_NONE = 2'd3
  } word_sel_e;
endpackage

// File: rtl/frac_serial_rx.sv
module frac_serial_rx
  import frac_div_pkg::*;
#(
  parameter int IW      = INT_W,
  parameter int FW      = FRAC_W,
  parameter int RW      = REF_W,
  parameter int INT_RST = 4,
  parameter int REF_RST = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ser_clk,
  input  logic          ser_dat,
  input  logic          ser_csn,
  output logic [IW-1:0] int_sh,
  output logic [FW-1:0] frac_sh,
  output logic [RW-1:0] ref_sh
);
  localparam int FRAME = SEL_W + FW;
  localparam int BCW   = $clog2(FRAME + 2);
  localparam int NLINE = 3;

  // line 0: clock, line 1: data, line 2: select
  logic [NLINE-1:0] raw;
  logic [2:0]       sy [NLINE];
  assign raw = {ser_csn, ser_dat, ser_clk};

  for (genvar g = 0; g < NLINE; g++) begin : g_sync
    always_ff @(posedge clk) begin
      if (!rst_n) sy[g] <= (g == 2) ? 3'b111 : 3'b000;
      else        sy[g] <= {sy[g][1:0], raw[g]};
    end
  end

  logic clk_rise, cs_low, cs_rise, cs_fall;
  assign clk_rise = sy[0][1] & ~sy[0][2];
  assign cs_low   = ~sy[2][1];
  assign cs_rise  = sy[2][1] & ~sy[2][2];
  assign cs_fall  = ~sy[2][1] & sy[2][2];

  logic [FRAME-1:0] shreg;
  logic [BCW-1:0]   nbits;
  word_sel_e        sel;
  assign sel = word_sel_e'(shreg[FRAME-1 -: SEL_W]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg   <= '0;
      nbits   <= '0;
      int_sh  <= IW'(INT_RST);
      frac_sh <= '0;
      ref_sh  <= RW'(REF_RST);
    end else begin
      if (cs_fall) begin
        nbits <= '0;
      end else if (clk_rise && cs_low) begin
        shreg <= {shreg[FRAME-2:0], sy[1][1]};
        if (nbits != '1) nbits <= nbits + 1'b1;
      end
      if (cs_rise && nbits == BCW'(FRAME)) begin
        case (sel)
          SEL_INT:  int_sh  <= shreg[IW-1:0];
          SEL_FRAC: frac_sh <= shreg[FW-1:0];
          SEL_REF:  ref_sh  <= shreg[RW-1:0];
          default:  ;
        endcase
      end
    end
  end
endmodule

// File: rtl/frac_ref_div.sv
module frac_ref_div
  import frac_div_pkg::*;
#(
  parameter int RW      = REF_W,
  parameter int REF_RST = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [RW-1:0] ref_sh,
  output logic          ref_pls
);
  localparam logic [RW-1:0] R_MIN = RW'(2);

  logic [RW-1:0] r_act, r_cnt, r_eff, r_last;
  assign r_eff  = (r_act < R_MIN) ? R_MIN : r_act;
  assign r_last = r_eff - RW'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      r_act   <= RW'(REF_RST);
      r_cnt   <= '0;
      ref_pls <= 1'b0;
    end else if (r_cnt == r_last) begin
      r_cnt   <= '0;
      ref_pls <= 1'b1;
      r_act   <= ref_sh;
    end else begin
      r_cnt   <= r_cnt + 1'b1;
      ref_pls <= 1'b0;
    end
  end
endmodule

// File: rtl/frac_loop_div.sv
module frac_loop_div
  import frac_div_pkg::*;
#(
  parameter int IW      = INT_W,
  parameter int FW      = FRAC_W,
  parameter int MW      = MOD_W,
  parameter int INT_RST = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] int_sh,
  input  logic [FW-1:0] frac_sh,
  input  logic [MW-1:0] mod_code,
  input  logic          pre_pls,
  output logic          mod_hi,
  output logic          fb_pls
);
  localparam int SW = FW + 2;

  logic [IW-1:0] n_act, n_cnt, n_eff, n_last;
  logic [FW-1:0] f_act, acc, f_eff;
  logic signed [SW-1:0] f_sum;
  logic [FW:0]   acc_sum;
  logic          boundary;

  assign n_eff  = (n_act == '0) ? IW'(1) : n_act;
  assign n_last = n_eff - IW'(1);
  assign boundary = pre_pls && (n_cnt == n_last);

  // signed sum of word and modulation, clamped to the word range
  assign f_sum = $signed({2'b00, f_act}) +
                 $signed({{(SW-MW){mod_code[MW-1]}}, mod_code});
  always_comb begin
    if (f_sum[SW-1])     f_eff = '0;
    else if (f_sum[FW])  f_eff = '1;
    else                 f_eff = f_sum[FW-1:0];
  end
  assign acc_sum = {1'b0, acc} + {1'b0, f_eff};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      n_act  <= IW'(INT_RST);
      f_act  <= '0;
      n_cnt  <= '0;
      acc    <= '0;
      mod_hi <= 1'b0;
      fb_pls <= 1'b0;
    end else if (boundary) begin
      n_cnt  <= '0;
      acc    <= acc_sum[FW-1:0];
      mod_hi <= acc_sum[FW];
      fb_pls <= 1'b1;
      n_act  <= int_sh;
      f_act  <= frac_sh;
    end else if (pre_pls) begin
      n_cnt  <= n_cnt + 1'b1;
      mod_hi <= 1'b0;
      fb_pls <= 1'b0;
    end else begin
      fb_pls <= 1'b0;
    end
  end
endmodule

// File: rtl/frac_divider_top.sv
module frac_divider_top
  import frac_div_pkg::*;
#(
  parameter int IW      = INT_W,
  parameter int FW      = FRAC_W,
  parameter int MW      = MOD_W,
  parameter int RW      = REF_W,
  parameter int INT_RST = 4,
  parameter int REF_RST = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ser_clk,
  input  logic          ser_dat,
  input  logic          ser_csn,
  input  logic [MW-1:0] mod_code,
  input  logic          pre_pls,
  output logic          mod_hi,
  output logic          fb_pls,
  output logic          ref_pls
);
  logic [IW-1:0] int_sh;
  logic [FW-1:0] frac_sh;
  logic [RW-1:0] ref_sh;

  frac_serial_rx #(.IW(IW), .FW(FW), .RW(RW), .INT_RST(INT_RST), .REF_RST(REF_RST)) u_rx (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_csn(ser_csn),
    .int_sh(int_sh), .frac_sh(frac_sh), .ref_sh(ref_sh)
  );

  frac_loop_div #(.IW(IW), .FW(FW), .MW(MW), .INT_RST(INT_RST)) u_loop (
    .clk(clk), .rst_n(rst_n), .int_sh(int_sh), .frac_sh(frac_sh),
    .mod_code(mod_code), .pre_pls(pre_pls), .mod_hi(mod_hi), .fb_pls(fb_pls)
  );

  frac_ref_div #(.RW(RW), .REF_RST(REF_RST)) u_ref (
    .clk(clk), .rst_n(rst_n), .ref_sh(ref_sh), .ref_pls(ref_pls)
  );
endmodule

// File: rtl/frac_divider_chk.sv
module frac_divider_chk (
  input logic clk,
  input logic rst_n,
  input logic pre_pls,
  input logic mod_hi,
  input logic fb_pls,
  input logic ref_pls
);
  // R4
  fb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fb_pls |=> !fb_pls);
  // R4
  fb_after_pre_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fb_pls |-> $past(pre_pls));
  // R5
  mod_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mod_hi) |-> fb_pls);
  // R5
  mod_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mod_hi) |-> $past(pre_pls));
  // R7
  ref_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_pls |=> !ref_pls);
endmodule

bind frac_divider_top frac_divider_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pre_pls(pre_pls),
  .mod_hi(mod_hi), .fb_pls(fb_pls), .ref_pls(ref_pls)
);

// File: tb/sim_frac_divider_top.sv
`timescale 1ns/1ps
module sim_frac_divider_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_dat = 1'b0, ser_csn = 1'b1;
  logic [11:0] mod_code = '0;
  logic pre_pls = 1'b0;
  logic mod_hi, fb_pls, ref_pls;

  int checks = 0;
  int errors = 0;

  // bench model state
  int m_n_act = 4, m_f_act = 0, m_n_sh = 4, m_f_sh = 0;
  int m_acc = 0, m_cnt = 0, m_mod = 0;
  bit last_fb;

  always #10 clk = ~clk;

  frac_divider_top u0 (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_csn(ser_csn),
    .mod_code(mod_code), .pre_pls(pre_pls), .mod_hi(mod_hi), .fb_pls(fb_pls), .ref_pls(ref_pls)
  );

  task automatic chk(input string tag, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s got %0d exp %0d", tag, what, got, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // frame: 2-bit select then 16 data bits, MSB first; nb bits are sent
  task automatic send(input int sel, input int data, input int nb);
    logic [17:0] w;
    w = {sel[1:0], data[15:0]};
    ser_csn = 1'b0; idle(3);
    for (int i = 0; i < nb; i++) begin
      ser_dat = w[17-i]; idle(3);
      ser_clk = 1'b1;    idle(3);
      ser_clk = 1'b0;
    end
    idle(3); ser_csn = 1'b1; idle(8);
    if (nb == 18) begin
      if (sel == 0) m_n_sh = data & 255;
      if (sel == 1) m_f_sh = data & 65535;
    end
  endtask

  task automatic set_mod(input int v);
    mod_code = v[11:0];
    m_mod = v;
  endtask

  task automatic pulse(input string tag);
    int nef, eff, s, efb, emh;
    @(negedge clk) pre_pls = 1'b1;
    @(negedge clk) pre_pls = 1'b0;
    nef = (m_n_act == 0) ? 1 : m_n_act;
    m_cnt++;
    if (m_cnt >= nef) begin
      eff = m_f_act + m_mod;
      if (eff < 0) eff = 0;
      if (eff > 65535) eff = 65535;
      s = m_acc + eff;
      emh = s >> 16;
      m_acc = s & 65535;
      m_n_act = m_n_sh;
      m_f_act = m_f_sh;
      m_cnt = 0;
      efb = 1;
    end else begin
      efb = 0;
      emh = 0;
    end
    last_fb = efb[0];
    chk("R4", "fb_pls", int'(fb_pls), efb);
    chk(tag, "mod_hi", int'(mod_hi), emh);
    @(negedge clk);
  endtask

  task automatic run(input int nb, input string tag);
    int seen = 0;
    while (seen < nb) begin
      pulse(tag);
      if (last_fb) seen++;
    end
  endtask

  task automatic measure(output int per);
    for (int k = 0; k < 2; k++) begin
      do @(negedge clk); while (!ref_pls);
    end
    per = 0;
    do begin @(negedge clk); per++; end while (!ref_pls);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int per;
    int fr [5] = '{0, 1, 'h5555, 'h8000, 'hFFFF};
    int md [4] = '{0, 2047, -2048, -1};
    idle(4);
    chk("R1", "fb_pls in reset", int'(fb_pls), 0);
    chk("R1", "mod_hi in reset", int'(mod_hi), 0);
    chk("R1", "ref_pls in reset", int'(ref_pls), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "fb_pls after reset", int'(fb_pls), 0);
    measure(per);
    chk("R1", "ref period default", per, 4);
    run(3, "R1");

    // R2: integer count 2, then sweep word x modulation
    send(0, 2, 18);
    run(2, "R2");
    foreach (fr[i]) begin
      send(1, fr[i], 18);
      foreach (md[j]) begin
        set_mod(md[j]);
        run(8, (md[j] == 0) ? "R5" : "R6");
      end
    end

    // R6 clamps at both ends
    set_mod(2047);  send(1, 'hFFF0, 18); run(6, "R6");
    set_mod(-2048); send(1, 100, 18);    run(6, "R6");
    set_mod(0);

    // R2: short frame and unused select leave the word alone
    send(1, 'h4000, 18); run(4, "R2");
    send(1, 'h1234, 17); run(6, "R2");
    send(3, 'h7777, 18); run(6, "R2");

    // R3: write in mid-cycle; old count finishes first
    send(0, 5, 18);
    run(1, "R3");
    pulse("R3");
    send(0, 3, 18);
    send(1, 'hC000, 18);
    run(4, "R3");
    send(0, 0, 18);
    run(4, "R4");

    // R7 reference ratios
    send(2, 3, 18);    measure(per); chk("R7", "ref period 3", per, 3);
    send(2, 1, 18);    measure(per); chk("R7", "ref period 1->2", per, 2);
    send(2, 0, 18);    measure(per); chk("R7", "ref period 0->2", per, 2);
    send(2, 1000, 18); measure(per); chk("R7", "ref period 1000", per, 1000);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule